// File: doc/BRIEF.md
# Endpoint Configuration Sequencer

This block holds the configuration words for the sixteen endpoint slots of a full-speed USB device controller and decides when FIFO memory may be laid out. Slot numbering is fixed: slot 0 is the control OUT endpoint, slot 1 is the control IN endpoint, and slot k (k = 2..15) is data endpoint k-1. Firmware must write all sixteen slots in ascending slot order, the two control slots included, even though their settings never change. Any write that breaks this order is rejected and the sequence starts again from slot 0.

When slot 15 is written in order, the block gives a one-cycle start pulse. It then walks the slots one per cycle and gives each enabled slot a byte offset into the FIFO RAM. Offsets are assigned in ascending slot order. A double-buffered slot takes twice its size. When the walk ends, the block raises a done flag, and an overflow flag if the layout does not fit in the configured memory depth.

A USB bus reset, signalled on its own input, disables every endpoint and discards the layout. Stored words and offsets can be read back through a combinational port at any time.

Top module: `ep_cfg_seq`

## Requirements
- R1: After rst_n is deasserted, every stored configuration word and every base offset reads zero, and alloc_start, alloc_done, seq_err and overflow are low.
- R2: A configuration word is {enable, double, dir_in, iso, size[SZ_W-1:0]}, with enable in the most significant bit and size in bytes in the low bits. An accepted write stores the word exactly, and rd_cfg returns the stored word for rd_idx in the same cycle, whether or not allocation has run.
- R3: A write whose wr_idx differs from the expected slot is not stored. It sets seq_err, and the expected slot returns to 0. seq_err stays set until the next allocation start or bus reset.
- R4: An in-order write of slot 15 (endpoint 14) produces alloc_start high for exactly the next cycle. No other write produces it.
- R5: Once allocation completes, each enabled slot's base equals the sum of the footprints of the enabled slots below it. The footprint is size, or 2*size when double is set. Disabled slots read base 0.
- R6: alloc_done goes high 16 cycles after the cycle in which alloc_start is high, and it is low while alloc_start is high.
- R7: overflow goes high together with alloc_done when the total footprint exceeds MEM_BYTES, and it is never high without alloc_done.
- R8: Writes that arrive while allocation is running are ignored. They change neither the stored words nor the expected slot.
- R9: A bus_reset cycle clears the enable bit of every slot, zeroes all bases, clears alloc_start, alloc_done, seq_err and overflow, aborts a running allocation and returns the expected slot to 0. A write in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | USB bus reset seen on the line, one cycle or more |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | IW | Slot index of the write |
| wr_cfg | input | CW | Configuration word to write |
| rd_idx | input | IW | Slot index for read-back |
| rd_cfg | output | CW | Stored configuration word of rd_idx |
| rd_base | output | TW | FIFO base offset of rd_idx |
| alloc_start | output | 1 | One-cycle pulse that starts allocation |
| alloc_done | output | 1 | Layout complete and valid |
| seq_err | output | 1 | An out-of-order write was seen |
| overflow | output | 1 | Layout exceeds MEM_BYTES |

## Verification
Two events can fall in the same cycle: the in-order write of slot 15, which would start allocation, and a bus reset. The bench raises bus_reset during that final write. The run passes only if no start pulse follows, the slot is not stored and the sequence restarts. A related collision is a bus reset that lands in the middle of the allocation walk; there, alloc_done must never rise and every base must read zero. A behavioural model steps alongside the design and is compared with it on every clock.

// File: rtl/ep_cfg_seq.sv
module ep_cfg_seq #(
  parameter int NUM_SLOTS = 16,
  parameter int SZ_W      = 10,
  parameter int MEM_BYTES = 2048,
  localparam int IW = $clog2(NUM_SLOTS),
  localparam int CW = SZ_W + 4,
  localparam int TW = SZ_W + 1 + IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_reset,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [CW-1:0] wr_cfg,
  input  logic [IW-1:0] rd_idx,
  output logic [CW-1:0] rd_cfg,
  output logic [TW-1:0] rd_base,
  output logic          alloc_start,
  output logic          alloc_done,
  output logic          seq_err,
  output logic          overflow
);
  localparam int EN_B = SZ_W + 3;
  localparam int DB_B = SZ_W + 2;
  localparam logic [IW-1:0] LAST = IW'(NUM_SLOTS - 1);

  logic [CW-1:0] cfg_q  [NUM_SLOTS];
  logic [TW-1:0] base_q [NUM_SLOTS];
  logic [IW-1:0] nxt, scan;
  logic          busy;
  logic [TW-1:0] total;

  wire [CW-1:0] cur      = cfg_q[scan];
  wire [TW-1:0] sz       = {{(TW-SZ_W){1'b0}}, cur[SZ_W-1:0]};
  wire [TW-1:0] foot     = cur[EN_B] ? (cur[DB_B] ? sz << 1 : sz) : '0;
  wire [TW-1:0] sum      = total + foot;
  wire          accept   = wr_en && !busy;
  wire          in_order = wr_idx == nxt;
  wire          last_wr  = accept && in_order && (nxt == LAST);

  assign rd_cfg  = cfg_q[rd_idx];
  assign rd_base = base_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || bus_reset) begin
      nxt <= '0; scan <= '0; busy <= 1'b0; total <= '0;
      alloc_start <= 1'b0; alloc_done <= 1'b0;
      seq_err <= 1'b0; overflow <= 1'b0;
    end else begin
      alloc_start <= last_wr;
      if (accept) begin
        if (!in_order) begin
          nxt     <= '0;
          seq_err <= 1'b1;
        end else if (nxt == LAST) nxt <= '0;
        else nxt <= nxt + 1'b1;
      end
      if (last_wr) begin
        busy <= 1'b1; scan <= '0; total <= '0;
        alloc_done <= 1'b0; overflow <= 1'b0; seq_err <= 1'b0;
      end
      if (busy) begin
        total <= sum;
        scan  <= scan + 1'b1;
        if (scan == LAST) begin
          busy       <= 1'b0;
          alloc_done <= 1'b1;
          overflow   <= sum > TW'(MEM_BYTES);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!rst_n) begin
        cfg_q[i]  <= '0;
        base_q[i] <= '0;
      end else if (bus_reset) begin
        cfg_q[i][EN_B] <= 1'b0;
        base_q[i]      <= '0;
      end else begin
        if (accept && in_order && wr_idx == IW'(i)) cfg_q[i] <= wr_cfg;
        if (busy && scan == IW'(i)) base_q[i] <= cur[EN_B] ? total : '0;
      end
    end
  end

  a_r3_err_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_order && !bus_reset) |=> (seq_err && nxt == '0));
  a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_start |=> !alloc_start);
  a_r6_no_done_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_start |-> !alloc_done);
  a_r7_ovf_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> alloc_done);
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !bus_reset) |=> $stable(nxt));
  a_r9_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!alloc_done && !alloc_start && !seq_err && !overflow && !busy));
endmodule

// File: tb/sim_ep_cfg_seq.sv
module sim_ep_cfg_seq;
  localparam int CLK_T = 10;
  localparam int MEM   = 2048;

  logic clk = 0, rst_n = 0, bus_reset = 0, wr_en = 0;
  logic [3:0] wr_idx = 0, rd_idx = 0;
  logic [13:0] wr_cfg = 0;
  logic [13:0] rd_cfg;
  logic [14:0] rd_base;
  logic alloc_start, alloc_done, seq_err, overflow;

  ep_cfg_seq #(.NUM_SLOTS(16), .SZ_W(10), .MEM_BYTES(MEM)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_cfg(wr_cfg), .rd_idx(rd_idx), .rd_cfg(rd_cfg),
    .rd_base(rd_base), .alloc_start(alloc_start), .alloc_done(alloc_done),
    .seq_err(seq_err), .overflow(overflow));

  always #(CLK_T/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit ended = 0;

  logic [13:0] mcfg [16];
  int mbase [16];
  int pend [16];
  int mexp = 0, mcnt = 0, ptot = 0;
  bit mstart = 0, mdone = 0, merr = 0, movf = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin mcfg[i] = 0; mbase[i] = 0; end
      mexp = 0; mcnt = 0; mstart = 0; mdone = 0; merr = 0; movf = 0;
    end else begin
      mstart = 0;
      if (bus_reset) begin
        for (int i = 0; i < 16; i++) begin mcfg[i][13] = 0; mbase[i] = 0; end
        mexp = 0; mcnt = 0; mdone = 0; merr = 0; movf = 0;
      end else if (mcnt > 0) begin
        mcnt--;
        if (mcnt == 0) begin
          mdone = 1; movf = ptot > MEM;
          for (int i = 0; i < 16; i++) mbase[i] = pend[i];
        end
      end else if (wr_en) begin
        if (int'(wr_idx) == mexp) begin
          mcfg[wr_idx] = wr_cfg;
          if (mexp == 15) begin
            mexp = 0; mstart = 1; mcnt = 16; mdone = 0; movf = 0; merr = 0;
            ptot = 0;
            for (int i = 0; i < 16; i++) begin
              if (mcfg[i][13]) begin
                pend[i] = ptot;
                ptot += int'(mcfg[i][9:0]) * (mcfg[i][12] ? 2 : 1);
              end else pend[i] = 0;
            end
          end else mexp++;
        end else begin
          merr = 1; mexp = 0;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !ended) begin
    chk("R2 R8 rd_cfg", rd_cfg, mcfg[rd_idx]);
    chk("R4 alloc_start", alloc_start, mstart);
    chk("R6 alloc_done", alloc_done, mdone);
    chk("R3 seq_err", seq_err, merr);
    chk("R7 overflow", overflow, movf);
    if (mcnt == 0) chk("R5 rd_base", rd_base, mbase[rd_idx]);
  end

  initial forever begin
    @(posedge clk); #1; rd_idx = rd_idx + 1;
  end

  function automatic logic [13:0] gen(input int p, input int s);
    int sz;
    if (s < 2) return {1'b1, 1'b0, s[0], 1'b0, 10'd64};
    sz = (p == 2) ? 1000 - s : (p * 37 + s * 53) % 40 + 8;
    return {((s + p) % 3) != 0, ((s * (p + 1)) % 2) == 1, s[0], (s % 5) == 0, 10'(sz)};
  endfunction

  task automatic wr(input int s, input logic [13:0] c);
    @(posedge clk); #1; wr_en = 1; wr_idx = 4'(s); wr_cfg = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; wr_en = 0; bus_reset = 0; end
  endtask

  task automatic full_seq(input int p);
    for (int s = 0; s < 16; s++) wr(s, gen(p, s));
  endtask

  initial begin
    #(CLK_T * 100000);
    if (!ended) begin
      ended = 1; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset done", alloc_done, 0);
    chk("R1 reset start", alloc_start, 0);
    chk("R1 reset err", seq_err, 0);
    chk("R1 reset ovf", overflow, 0);
    chk("R1 reset cfg", rd_cfg, 0);
    chk("R1 reset base", rd_base, 0);
    idle(20);
    // R3: order broken after slot 2
    for (int s = 0; s < 3; s++) wr(s, gen(1, s));
    wr(5, gen(1, 5));
    idle(3);
    wr(3, gen(1, 3));
    idle(20);
    // R4 R5 R6: normal layout, then writes during the walk (R8)
    full_seq(0);
    wr(0, 14'h3fff); wr(1, 14'h1234); wr(2, 14'h0abc);
    idle(30);
    full_seq(1);
    idle(30);
    // R7: large sizes overflow
    full_seq(2);
    idle(30);
    // R9: bus reset during the walk
    full_seq(0);
    idle(5);
    @(posedge clk); #1; bus_reset = 1;
    idle(1);
    @(negedge clk);
    chk("R9 done after reset", alloc_done, 0);
    chk("R9 err after reset", seq_err, 0);
    idle(30);
    // R9: bus reset in the same cycle as the final write
    for (int s = 0; s < 15; s++) wr(s, gen(1, s));
    @(posedge clk); #1; wr_en = 1; wr_idx = 15; wr_cfg = gen(1, 15); bus_reset = 1;
    idle(1);
    @(negedge clk);
    chk("R9 no start on collision", alloc_start, 0);
    idle(25);
    full_seq(3);
    idle(30);
    // R9: bus reset mid-sequence then restart
    for (int s = 0; s < 6; s++) wr(s, gen(3, s));
    @(posedge clk); #1; wr_en = 0; bus_reset = 1;
    idle(2);
    full_seq(1);
    idle(40);
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule